// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five numbered localities (0 to 4) owns a shared security-device register window at any moment. Software first writes a locality number into a selection register. Every later access-register write is then attributed to that locality. One write can carry several commands: give up ownership, take ownership by force, or ask for ownership. The arbiter keeps track of the current owner, a waiting flag for each locality and a "was preempted" flag for each locality. From this state it forms the byte that the selected locality reads back from its access register.

Ownership follows priority and can be taken away. A locality asking while nobody owns the window gets it at once. A locality asking while another one owns it is put in the waiting list. A locality with a higher number than the owner can force a takeover, and the old owner is marked as preempted. A locality with a lower number that tries a takeover gets nothing. When the owner gives up the window, the highest-numbered waiting locality takes over in the same write.

Top module: `loc_arb`

## Requirements
- R1: After reset no locality owns the window, all waiting and preempted flags are clear, the selection register holds 0, and the access byte of any locality reads 0x81.
- R2: A write of 0 to 4 to the selection register (`wr_addr`=1) stores that value. A write of 5 or more leaves the stored value unchanged. Reading `rd_addr`=1 returns the stored value in bits 2:0, with the upper bits zero.
- R3: The access byte (`rd_addr`=0) shows the selected locality's state. Bit 7 and bit 0 always read 1. Bits 6 and 3 always read 0. Bit 5 means "this locality owns the window", bit 4 means preempted, bit 2 means pending and bit 1 means waiting.
- R4: An access write with bit 1 set, made while no locality owns the window, makes the writing locality the owner on the next clock.
- R5: An access write with bit 5 set from the owner gives up ownership. If nobody is waiting, no locality owns the window afterwards. The same write from a locality that is not the owner changes nothing.
- R6: An access write with bit 1 set, made while a different locality owns the window, sets the writer's waiting flag. Every locality other than that waiter reads bit 2 (pending) as 1 while the waiting flag stays set.
- R7: An access write with bit 3 set from a locality numbered higher than the owner makes the writer the owner and sets the old owner's preempted flag. If nobody owns the window, the writer simply becomes the owner. The same write from a lower-numbered locality changes nothing.
- R8: An access write with bit 4 set clears the writer's preempted flag.
- R9: When the owner gives up the window, the highest-numbered waiting locality becomes the owner and its waiting flag clears. The owner never has its own waiting flag set.
- R10: When one write sets several command bits, they act in this order: give up (bit 5), then forced takeover (bit 3), then request (bit 1).
- R11: `active_valid` is high exactly while some locality owns the window. `active_loc` gives the owner's number, and reads 0 while `active_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block in step with the clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register target: 0 = access register, 1 = selection register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 = access byte of the selected locality, 1 = selection register |
| rd_data | output | 8 | Combinational read data |
| active_valid | output | 1 | High while some locality owns the window |
| active_loc | output | 3 | Number of the owning locality |

## Verification
Some properties are checked on every clock cycle:
- the owner never carries a waiting flag;
- a request made with no owner is granted on the next clock;
- a lone give-up with nobody waiting leaves the window free;
- a takeover attempt from a lower number leaves the owner in place;
- a preempted flag only appears after a takeover write;
- an out-of-range selection value never changes the selection register.

The bench scenarios cover what needs a whole sequence of writes:
- pending shown to every other locality while a request waits;
- the hand-over chain to the highest waiter;
- clearing a preempted flag;
- the ordering of combined command bits;
- the fixed bits of the read-back byte.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int DEF_NUM_LOC = 5;
  localparam int DATA_W      = 8;

  // Access byte field positions
  localparam int B_REGOK  = 7;
  localparam int B_OWNER  = 5;
  localparam int B_LOST   = 4;
  localparam int B_FORCE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_WAIT   = 1;
  localparam int B_ESTAB  = 0;

  typedef enum logic {
    TGT_ACCESS = 1'b0,
    TGT_LOCSEL = 1'b1
  } reg_tgt_e;
endpackage

// File: rtl/loc_sel_reg.sv
module loc_sel_reg
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = DEF_NUM_LOC,
  localparam int LW = $clog2(NUM_LOC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [LW-1:0]     sel
);
  logic [LW-1:0] sel_q;
  logic          in_range;
  logic          sel_en;

  always_comb begin
    in_range = (int'(wdata) < NUM_LOC);
    sel_en   = we && in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= wdata[LW-1:0];
  end

  assign sel = sel_q;

  // R2: out-of-range select value leaves the register untouched
  a_r2_bad_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(wdata) >= NUM_LOC) |=> $stable(sel_q));
endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int N = 5,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/loc_own_core.sv
module loc_own_core
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = DEF_NUM_LOC,
  localparam int LW = $clog2(NUM_LOC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [LW-1:0]      loc,
  output logic               own_v,
  output logic [LW-1:0]      own_loc,
  output logic [NUM_LOC-1:0] wait_o,
  output logic [NUM_LOC-1:0] lost_o
);
  logic               own_v_q,  own_v_d;
  logic [LW-1:0]      own_q,    own_d;
  logic [NUM_LOC-1:0] wait_q,   wait_d;
  logic [NUM_LOC-1:0] lost_q,   lost_d;
  logic               pick_found;
  logic [LW-1:0]      pick_idx;
  logic               is_owner;

  loc_prio_pick #(.N(NUM_LOC)) u_pick (
    .req   (wait_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign is_owner = own_v_q && (own_q == loc);

  // Next state: give-up, then forced takeover, then request
  always_comb begin
    own_v_d = own_v_q;
    own_d   = own_q;
    wait_d  = wait_q;
    lost_d  = lost_q;
    if (wdata[B_LOST]) lost_d[loc] = 1'b0;
    if (wdata[B_OWNER] && is_owner) begin
      own_v_d = pick_found;
      own_d   = pick_found ? pick_idx : own_q;
      if (pick_found) wait_d[pick_idx] = 1'b0;
    end
    if (wdata[B_FORCE] && (!own_v_d || loc > own_d)) begin
      if (own_v_d) lost_d[own_d] = 1'b1;
      own_v_d      = 1'b1;
      own_d        = loc;
      wait_d[loc]  = 1'b0;
    end
    if (wdata[B_WAIT] && !(own_v_d && own_d == loc)) begin
      if (!own_v_d) begin
        own_v_d = 1'b1;
        own_d   = loc;
      end else begin
        wait_d[loc] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v_q <= 1'b0;
      own_q   <= '0;
      wait_q  <= '0;
      lost_q  <= '0;
    end else if (acc_we) begin
      own_v_q <= own_v_d;
      own_q   <= own_d;
      wait_q  <= wait_d;
      lost_q  <= lost_d;
    end
  end

  assign own_v   = own_v_q;
  assign own_loc = own_v_q ? own_q : '0;
  assign wait_o  = wait_q;
  assign lost_o  = lost_q;

  // R9: the owner never carries its own waiting flag
  a_r9_owner_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    own_v_q |-> !wait_q[own_q]);

  // R4: request with no owner is granted on the next clock
  a_r4_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && wdata[B_WAIT] && !own_v_q) |=> (own_v_q && own_q == $past(loc)));

  // R5: lone give-up by the owner with nobody waiting frees the window
  a_r5_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && wdata[B_OWNER] && !wdata[B_FORCE] && !wdata[B_WAIT] &&
     own_v_q && own_q == loc && wait_q == '0) |=> !own_v_q);

  // R7: takeover from a lower number leaves the owner in place
  a_r7_low_force_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && wdata[B_FORCE] && own_v_q && loc < own_q) |=>
    (own_v_q && own_q == $past(own_q)));

  // R7: a preempted flag appears only after a takeover write
  a_r7_lost_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((lost_q & ~$past(lost_q)) != '0) |-> $past(acc_we && wdata[B_FORCE]));
endmodule

// File: rtl/loc_acc_view.sv
module loc_acc_view
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = DEF_NUM_LOC,
  localparam int LW = $clog2(NUM_LOC)
) (
  input  logic [LW-1:0]      loc,
  input  logic               own_v,
  input  logic [LW-1:0]      own_loc,
  input  logic [NUM_LOC-1:0] wait_f,
  input  logic [NUM_LOC-1:0] lost_f,
  output logic [DATA_W-1:0]  acc_byte
);
  logic [NUM_LOC-1:0] others;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_mask
    assign others[g] = wait_f[g] && (LW'(g) != loc);
  end

  always_comb begin
    acc_byte          = '0;
    acc_byte[B_REGOK] = 1'b1;
    acc_byte[B_ESTAB] = 1'b1;
    acc_byte[B_OWNER] = own_v && (own_loc == loc);
    acc_byte[B_LOST]  = lost_f[loc];
    acc_byte[B_PEND]  = |others;
    acc_byte[B_WAIT]  = wait_f[loc];
  end
endmodule

// File: rtl/loc_arb.sv
module loc_arb
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = DEF_NUM_LOC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       active_valid,
  output logic [$clog2(NUM_LOC)-1:0] active_loc
);
  localparam int LW = $clog2(NUM_LOC);

  logic [1:0]         rst_pipe;
  logic               rst_n_i;
  logic [LW-1:0]      sel;
  logic               sel_we, acc_we;
  logic [NUM_LOC-1:0] wait_f, lost_f;
  logic [DATA_W-1:0]  acc_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  assign sel_we = wr_en && (reg_tgt_e'(wr_addr) == TGT_LOCSEL);
  assign acc_we = wr_en && (reg_tgt_e'(wr_addr) == TGT_ACCESS);

  loc_sel_reg #(.NUM_LOC(NUM_LOC)) u_sel (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (sel_we),
    .wdata (wr_data),
    .sel   (sel)
  );

  loc_own_core #(.NUM_LOC(NUM_LOC)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .acc_we  (acc_we),
    .wdata   (wr_data),
    .loc     (sel),
    .own_v   (active_valid),
    .own_loc (active_loc),
    .wait_o  (wait_f),
    .lost_o  (lost_f)
  );

  loc_acc_view #(.NUM_LOC(NUM_LOC)) u_view (
    .loc      (sel),
    .own_v    (active_valid),
    .own_loc  (active_loc),
    .wait_f   (wait_f),
    .lost_f   (lost_f),
    .acc_byte (acc_byte)
  );

  always_comb begin
    if (reg_tgt_e'(rd_addr) == TGT_LOCSEL) rd_data = {{(8-LW){1'b0}}, sel};
    else                                   rd_data = acc_byte;
  end
endmodule

// File: tb/loc_arb_bench.sv
module loc_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       active_valid;
  logic [2:0] active_loc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    bit         kind;   // 0: rd_data, 1: owner outputs
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  loc_arb u_loc_arb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .active_valid(active_valid), .active_loc(active_loc)
  );

  // Monitor: compare mid low phase
  always begin
    @(negedge clk);
    #5;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.kind ? {4'b0, active_valid, active_loc} : rd_data;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic acc(input int l, input logic [7:0] d);
    wr(1'b1, 8'(l));
    wr(1'b0, d);
  endtask

  task automatic push(input bit k, input bit ra, input logic [7:0] e, input string t);
    item_t it;
    @(negedge clk);
    rd_addr = ra;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic chk_acc(input int l, input logic [7:0] e, input string t);
    wr(1'b1, 8'(l));
    push(1'b0, 1'b0, e, t);
  endtask

  task automatic chk_own(input bit v, input int l, input string t);
    push(1'b1, 1'b0, {4'b0, v, 3'(l)}, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    push(1'b0, 1'b1, 8'h00, "R1 select after reset");
    chk_own(1'b0, 0, "R1 no owner after reset");
    chk_acc(4, 8'h81, "R1 R3 idle access byte");
    chk_acc(0, 8'h81, "R1 idle access byte loc0");

    // R2 select register
    wr(1'b1, 8'd3);  push(1'b0, 1'b1, 8'h03, "R2 store 3");
    wr(1'b1, 8'd5);  push(1'b0, 1'b1, 8'h03, "R2 ignore 5");
    wr(1'b1, 8'hFF); push(1'b0, 1'b1, 8'h03, "R2 ignore FF");
    wr(1'b1, 8'd4);  push(1'b0, 1'b1, 8'h04, "R2 store 4");

    // R4 request while idle
    acc(0, 8'h02);
    chk_own(1'b1, 0, "R4 R11 loc0 owner");
    chk_acc(0, 8'hA1, "R4 R3 loc0 byte");

    // R6 request while owned
    acc(2, 8'h02);
    chk_acc(2, 8'h83, "R6 waiter byte");
    chk_acc(0, 8'hA5, "R6 owner sees pending");
    chk_acc(1, 8'h85, "R6 bystander sees pending");

    // R7 higher takeover, then lower attempt
    acc(3, 8'h08);
    chk_own(1'b1, 3, "R7 takeover by loc3");
    chk_acc(3, 8'hA5, "R7 new owner byte");
    chk_acc(0, 8'h95, "R7 old owner preempted");
    acc(1, 8'h08);
    chk_own(1'b1, 3, "R7 low takeover ignored");
    chk_acc(1, 8'h85, "R7 low locality byte");

    // R8 clear preempted
    acc(0, 8'h10);
    chk_acc(0, 8'h85, "R8 preempted cleared");

    // R5 give-up from non-owner
    acc(2, 8'h20);
    chk_own(1'b1, 3, "R5 non-owner give-up ignored");
    chk_acc(2, 8'h83, "R5 waiter kept");

    // R9 hand-over to highest waiter
    acc(1, 8'h02);
    chk_acc(1, 8'h87, "R9 second waiter");
    acc(3, 8'h20);
    chk_own(1'b1, 2, "R9 highest waiter granted");
    chk_acc(2, 8'hA5, "R9 new owner wait cleared");
    chk_acc(1, 8'h83, "R9 remaining waiter");
    acc(2, 8'h20);
    chk_own(1'b1, 1, "R9 next waiter granted");
    chk_acc(1, 8'hA1, "R9 last owner byte");
    acc(1, 8'h20);
    chk_own(1'b0, 0, "R5 R11 window free");

    // R10 combined command bits
    acc(4, 8'h02);
    acc(1, 8'h02);
    acc(4, 8'h22);
    chk_own(1'b1, 1, "R10 give-up then request: loc1 owns");
    chk_acc(4, 8'h83, "R10 loc4 now waiting");
    chk_acc(1, 8'hA5, "R10 loc1 byte");
    acc(1, 8'h28);
    chk_own(1'b1, 4, "R10 give-up then low takeover");
    chk_acc(4, 8'hA1, "R10 loc4 owner");
    chk_acc(1, 8'h81, "R10 loc1 not preempted");
    acc(4, 8'h20);

    // R7 takeover with no owner
    acc(2, 8'h08);
    chk_own(1'b1, 2, "R7 takeover while idle");
    chk_acc(4, 8'h81, "R7 no preempted flag when idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule